// File: doc/BRIEF.md
# Fractional-Addend Precision Time Counter

This block keeps a free-running nanosecond time count for the timing unit of a network interface. On each tick of its reference clock it adds a per-tick increment into an accumulator. The increment is held as Q16.32 fixed-point nanoseconds. With the default 600 MHz reference, the nominal increment is the 48-bit value 0x1_AAAA_AAAA, which is about 1.6667 ns. The accumulator keeps 32 fractional bits internally. Only its integer part forms the visible 64-bit time.

Software drives the block through a simple 32-bit register port. It sets an enable bit and a tick interval. It stages a new increment and a start time, then makes either one take effect with a command. The command bits act once and never stay set. The 64-bit time is read as two words. Reading the low word freezes the matching high word, so a following high-word read returns the same instant. The datapath gets the low 40 bits of the time on a plain output, without a handshake.

There is no valid/ready at either edge. Every write is accepted in the cycle it is presented. Every read returns its data in the cycle after the request. There is no back-pressure.

Top module: `ptc_timer`

## Requirements
- R1: After reset the time is 0, the clock is disabled (CTRL bit 0 = 0) with interval 1 (CTRL bits 11:8 = 1, so CTRL reads 0x100), and both staged and active increments equal the nominal 0x1_AAAA_AAAA (INC_FRAC at address 1 reads 0xAAAAAAAA, INC_INT at address 2 reads 1).
- R2: Each tick adds the active 48-bit increment to a 96-bit accumulator. The visible time is the upper 64 bits, and the fractional part carries over across ticks and across increment changes. After a load of value T followed by N1 ticks at increment A1 and N2 ticks at A2, the time equals ((T<<32) + N1*A1 + N2*A2) >> 32.
- R3: While CTRL bit 0 is 0 there are no ticks and the time holds its value.
- R4: With CTRL bit 0 set, a tick occurs once every V enabled cycles, where V is CTRL bits 11:8; V of 0 or 1 ticks on every cycle. The divider restarts whenever the clock is disabled, so N enabled cycles give floor(N/V) ticks.
- R5: Writing CMD (address 5) with bit 0 set loads the time from LOAD_HI (address 4, bits 63:32) and LOAD_LO (address 3, bits 31:0) and clears the fraction. At that edge the load takes precedence over a tick.
- R6: Writing CMD with bit 1 set copies the staged increment, INC_INT (address 2, bits 15:0 integer ns) and INC_FRAC (address 1, fraction), into the active increment. Ticks after that edge use it; until then the previous increment stays in use.
- R7: For 4 cycles after an apply command, writes to INC_FRAC and INC_INT are ignored. A write on the fifth cycle or later is accepted.
- R8: A read of TIME_LO (address 6) returns time bits 31:0 and snapshots bits 63:32. A read of TIME_HI (address 7) returns that snapshot. Read data appears one cycle after the read request.
- R9: The datapath output ts_out always equals the low 40 bits of the time.
- R10: CTRL, INC_FRAC, INC_INT, LOAD_LO and LOAD_HI read back what was last accepted into them, and CMD always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| ts_out | output | 40 | Truncated time to the datapath |

## Verification
A fault in the fraction surfaces only after enough ticks for the error to carry into a whole nanosecond. The bench therefore runs tens to hundreds of ticks with random fractional increments and compares against exact 128-bit arithmetic. A wrong divider or enable path changes the tick count, so the time is off by a whole increment at the next readback. A stale snapshot or a missed staging lock appears at once as a wrong word on rd_data. A lost load precedence appears within two ticks.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL     = 3'd0,
    REG_INC_FRAC = 3'd1,
    REG_INC_INT  = 3'd2,
    REG_LOAD_LO  = 3'd3,
    REG_LOAD_HI  = 3'd4,
    REG_CMD      = 3'd5,
    REG_TIME_LO  = 3'd6,
    REG_TIME_HI  = 3'd7
  } reg_addr_e;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_IVAL_LSB = 8;
  localparam int unsigned CMD_LOAD_BIT  = 0;
  localparam int unsigned CMD_APPLY_BIT = 1;

  // nominal per-tick increment in fixed point with 32 fractional bits
  function automatic logic [63:0] nominal_inc(input logic [63:0] ref_hz);
    logic [63:0] num;
    num = 64'd1_000_000_000 << 32;
    return num / ref_hz;
  endfunction

endpackage

// File: rtl/ptc_regs.sv
module ptc_regs
  import ptc_pkg::*;
#(
  parameter int unsigned INT_W    = 16,
  parameter int unsigned FRAC_W   = 32,
  parameter int unsigned IVAL_W   = 4,
  parameter int unsigned HOLD_CYC = 4,
  parameter logic [INT_W+FRAC_W-1:0] RESET_INC = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [DATA_W-1:0]         cfg_rdata,
  output logic                      en_o,
  output logic [IVAL_W-1:0]         ival_o,
  output logic [INT_W+FRAC_W-1:0]   active_inc_o,
  output logic [2*DATA_W-1:0]       load_val_o,
  output logic                      load_o
);

  localparam int unsigned INC_W  = INT_W + FRAC_W;
  localparam int unsigned LOCK_W = $clog2(HOLD_CYC + 1);

  logic              en_q;
  logic [IVAL_W-1:0] ival_q;
  logic [FRAC_W-1:0] stage_frac_q;
  logic [INT_W-1:0]  stage_int_q;
  logic [DATA_W-1:0] load_lo_q, load_hi_q;
  logic [INC_W-1:0]  active_q;
  logic [LOCK_W-1:0] lock_q;

  logic wr_ctrl, wr_frac, wr_int, wr_lo, wr_hi, wr_cmd;
  logic apply, locked;

  always_comb begin
    wr_ctrl = wr_en && (wr_addr == REG_CTRL);
    wr_frac = wr_en && (wr_addr == REG_INC_FRAC);
    wr_int  = wr_en && (wr_addr == REG_INC_INT);
    wr_lo   = wr_en && (wr_addr == REG_LOAD_LO);
    wr_hi   = wr_en && (wr_addr == REG_LOAD_HI);
    wr_cmd  = wr_en && (wr_addr == REG_CMD);
    apply   = wr_cmd && wr_data[CMD_APPLY_BIT];
    load_o  = wr_cmd && wr_data[CMD_LOAD_BIT];
    locked  = (lock_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q         <= 1'b0;
      ival_q       <= IVAL_W'(1);
      stage_frac_q <= RESET_INC[FRAC_W-1:0];
      stage_int_q  <= RESET_INC[INC_W-1:FRAC_W];
      load_lo_q    <= '0;
      load_hi_q    <= '0;
      active_q     <= RESET_INC;
      lock_q       <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= wr_data[CTRL_EN_BIT];
        ival_q <= wr_data[CTRL_IVAL_LSB +: IVAL_W];
      end
      if (wr_frac && !locked) stage_frac_q <= wr_data[FRAC_W-1:0];
      if (wr_int && !locked)  stage_int_q  <= wr_data[INT_W-1:0];
      if (wr_lo) load_lo_q <= wr_data;
      if (wr_hi) load_hi_q <= wr_data;
      if (apply) begin
        active_q <= {stage_int_q, stage_frac_q};
        lock_q   <= LOCK_W'(HOLD_CYC);
      end else if (locked) begin
        lock_q <= lock_q - 1'b1;
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (rd_addr)
      REG_CTRL: begin
        cfg_rdata[CTRL_EN_BIT]               = en_q;
        cfg_rdata[CTRL_IVAL_LSB +: IVAL_W]   = ival_q;
      end
      REG_INC_FRAC: cfg_rdata[FRAC_W-1:0] = stage_frac_q;
      REG_INC_INT:  cfg_rdata[INT_W-1:0]  = stage_int_q;
      REG_LOAD_LO:  cfg_rdata = load_lo_q;
      REG_LOAD_HI:  cfg_rdata = load_hi_q;
      default:      cfg_rdata = '0;
    endcase
  end

  assign en_o         = en_q;
  assign ival_o       = ival_q;
  assign active_inc_o = active_q;
  assign load_val_o   = {load_hi_q, load_lo_q};

  // R7
  stage_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_INC_FRAC && lock_q != '0) |=> $stable(stage_frac_q));

  // R6
  apply_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_CMD && wr_data[CMD_APPLY_BIT])
      |=> active_q == $past({stage_int_q, stage_frac_q}));

endmodule

// File: rtl/ptc_tickgen.sv
module ptc_tickgen #(
  parameter int unsigned IVAL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [IVAL_W-1:0] ival_i,
  output logic              tick_o
);

  logic [IVAL_W-1:0] div_q;
  logic              every_cycle;

  always_comb begin
    every_cycle = (ival_i <= IVAL_W'(1));
    tick_o      = en_i && (every_cycle || (div_q == ival_i - IVAL_W'(1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (!en_i)   div_q <= '0;
    else if (tick_o)  div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end

  // R4
  every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && ival_i <= IVAL_W'(1)) |-> tick_o);

  // R3
  no_tick_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !tick_o);

  // R4
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && ival_i > IVAL_W'(1)) |-> div_q < ival_i);

endmodule

// File: rtl/ptc_accum.sv
module ptc_accum #(
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = 32,
  parameter int unsigned NS_W   = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_i,
  input  logic                    load_i,
  input  logic [NS_W-1:0]         load_val_i,
  input  logic [INT_W+FRAC_W-1:0] inc_i,
  output logic [NS_W-1:0]         ns_o
);

  localparam int unsigned INC_W = INT_W + FRAC_W;
  localparam int unsigned ACC_W = NS_W + FRAC_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] inc_ext;

  assign inc_ext = {{(ACC_W-INC_W){1'b0}}, inc_i};
  assign ns_o    = acc_q[ACC_W-1 -: NS_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (load_i) acc_q <= {load_val_i, {FRAC_W{1'b0}}};
    else if (tick_i) acc_q <= acc_q + inc_ext;
  end

  logic [NS_W-1:0] inc_whole;
  assign inc_whole = {{(NS_W-INT_W){1'b0}}, inc_i[INC_W-1:FRAC_W]};

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(ns_o));

  // R2
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i) |=> ((ns_o - $past(ns_o)) == $past(inc_whole)) ||
                            ((ns_o - $past(ns_o)) == $past(inc_whole) + 1'b1));

  // R5
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (ns_o == $past(load_val_i)) && (acc_q[FRAC_W-1:0] == '0));

endmodule

// File: rtl/ptc_readback.sv
module ptc_readback
  import ptc_pkg::*;
#(
  parameter int unsigned NS_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] cfg_rdata,
  input  logic [NS_W-1:0]   ns_i,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] snap_q;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    case (rd_addr)
      REG_TIME_LO: rd_next = ns_i[DATA_W-1:0];
      REG_TIME_HI: rd_next = snap_q;
      default:     rd_next = cfg_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      rd_q   <= '0;
    end else if (rd_en) begin
      rd_q <= rd_next;
      if (rd_addr == REG_TIME_LO) snap_q <= ns_i[NS_W-1:DATA_W];
    end
  end

  assign rd_data = rd_q;

  // R8
  lo_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == REG_TIME_LO) |=> rd_data == $past(ns_i[DATA_W-1:0]));

  // R8
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_addr == REG_TIME_LO) |=> $stable(snap_q));

endmodule

// File: rtl/ptc_timer.sv
module ptc_timer
  import ptc_pkg::*;
#(
  parameter logic [63:0] REF_HZ   = 64'd600_000_000,
  parameter int unsigned INT_W    = 16,
  parameter int unsigned FRAC_W   = 32,
  parameter int unsigned TS_W     = 40,
  parameter int unsigned IVAL_W   = 4,
  parameter int unsigned HOLD_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [2:0]        rd_addr,
  output logic [31:0]       rd_data,
  output logic [TS_W-1:0]   ts_out
);

  localparam int unsigned NS_W  = 2 * DATA_W;
  localparam int unsigned INC_W = INT_W + FRAC_W;
  localparam logic [63:0] NOM64 = nominal_inc(REF_HZ);
  localparam logic [INC_W-1:0] NOMINAL = NOM64[INC_W-1:0];

  logic              en;
  logic [IVAL_W-1:0] ival;
  logic [INC_W-1:0]  active_inc;
  logic [NS_W-1:0]   load_val;
  logic              load;
  logic              tick;
  logic [NS_W-1:0]   ns;
  logic [DATA_W-1:0] cfg_rdata;

  ptc_regs #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .IVAL_W(IVAL_W),
    .HOLD_CYC(HOLD_CYC), .RESET_INC(NOMINAL)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .cfg_rdata(cfg_rdata),
    .en_o(en), .ival_o(ival), .active_inc_o(active_inc),
    .load_val_o(load_val), .load_o(load)
  );

  ptc_tickgen #(.IVAL_W(IVAL_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en_i(en), .ival_i(ival), .tick_o(tick)
  );

  ptc_accum #(.INT_W(INT_W), .FRAC_W(FRAC_W), .NS_W(NS_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(load),
    .load_val_i(load_val), .inc_i(active_inc), .ns_o(ns)
  );

  ptc_readback #(.NS_W(NS_W)) u_rb (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .cfg_rdata(cfg_rdata), .ns_i(ns), .rd_data(rd_data)
  );

  assign ts_out = ns[TS_W-1:0];

endmodule

// File: tb/ptc_timer_bench.sv
`timescale 1ns/1ps
module ptc_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [39:0] ts_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  localparam logic [47:0] NOM = 48'h1_AAAA_AAAA;

  always #2 clk = ~clk;

  ptc_timer u_ptc_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .ts_out(ts_out)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic read_time(output logic [63:0] t);
    logic [31:0] lo, hi;
    rd(3'd6, lo);
    rd(3'd7, hi);
    t = {hi, lo};
  endtask

  task automatic load_time(input logic [63:0] t);
    wr(3'd3, t[31:0]);
    wr(3'd4, t[63:32]);
    wr(3'd5, 32'h1);
  endtask

  task automatic set_inc(input logic [47:0] a);
    wr(3'd1, a[31:0]);
    wr(3'd2, {16'h0, a[47:32]});
    wr(3'd5, 32'h2);
    repeat (5) @(negedge clk);
  endtask

  // n enabled cycles at interval v
  task automatic run(input int n, input logic [3:0] v);
    wr(3'd0, {20'h0, v, 8'h01});
    repeat (n - 1) @(negedge clk);
    wr(3'd0, {20'h0, v, 8'h00});
  endtask

  function automatic logic [63:0] expect_ns(input logic [63:0] t,
      input logic [47:0] a1, input int n1, input logic [47:0] a2, input int n2);
    logic [127:0] acc;
    acc = {32'h0, t, 32'h0} + 128'(n1) * {80'h0, a1} + 128'(n2) * {80'h0, a2};
    return acc[95:32];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] t, t2;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    read_time(t);
    check("R1 time", t, 64'h0);
    rd(3'd0, d); check("R1 ctrl", {32'h0, d}, 64'h100);
    rd(3'd1, d); check("R1 inc_frac", {32'h0, d}, 64'hAAAA_AAAA);
    rd(3'd2, d); check("R1 inc_int", {32'h0, d}, 64'h1);
    check("R1 ts_out", {24'h0, ts_out}, 64'h0);

    // R2 nominal increment, 600 ticks
    run(600, 4'd1);
    read_time(t);
    check("R2 nominal 600 ticks", t, expect_ns(64'h0, NOM, 600, NOM, 0));

    // R3 disabled holds
    repeat (20) @(negedge clk);
    read_time(t2);
    check("R3 hold while disabled", t2, t);

    // R4 interval 3 and interval 0
    load_time(64'd0);
    set_inc(48'h2_0000_0000);
    run(10, 4'd3);
    read_time(t);
    check("R4 interval 3", t, 64'd6);
    run(5, 4'd0);
    read_time(t);
    check("R4 interval 0", t, 64'd16);

    // R10 readback and CMD reads zero
    wr(3'd3, 32'hDEAD_BEEF);
    wr(3'd4, 32'h0123_4567);
    rd(3'd3, d); check("R10 load_lo", {32'h0, d}, 64'hDEAD_BEEF);
    rd(3'd4, d); check("R10 load_hi", {32'h0, d}, 64'h0123_4567);
    rd(3'd5, d); check("R10 cmd reads 0", {32'h0, d}, 64'h0);
    rd(3'd0, d); check("R10 ctrl", {32'h0, d}, 64'h000);

    // R5 load, then R9 ts_out
    wr(3'd5, 32'h1);
    read_time(t);
    check("R5 load value", t, 64'h0123_4567_DEAD_BEEF);
    check("R9 ts_out", {24'h0, ts_out}, 64'h67_DEAD_BEEF);

    // R5 load wins over tick and clears fraction
    load_time(64'd100);
    set_inc(48'h1_8000_0000);
    run(7, 4'd1);
    wr(3'd3, 32'd1000);
    wr(3'd4, 32'd0);
    wr(3'd0, 32'h101);
    wr(3'd5, 32'h1);
    wr(3'd0, 32'h100);
    read_time(t);
    check("R5 load priority and fraction clear", t, 64'd1001);

    // R7 staging locked after apply
    wr(3'd1, 32'h1111_1111);
    wr(3'd5, 32'h2);
    wr(3'd1, 32'h2222_2222);
    rd(3'd1, d);
    check("R7 write ignored while locked", {32'h0, d}, 64'h1111_1111);
    repeat (4) @(negedge clk);
    wr(3'd1, 32'h3333_3333);
    rd(3'd1, d);
    check("R7 write accepted after lock", {32'h0, d}, 64'h3333_3333);

    // R6 new increment used only after apply
    load_time(64'd0);
    wr(3'd2, 32'd5);
    wr(3'd1, 32'h0);
    run(4, 4'd1);
    read_time(t);
    check("R6 staged not yet active", t, expect_ns(64'd0, 48'h1_1111_1111, 4, 48'h0, 0));
    wr(3'd5, 32'h2);
    repeat (5) @(negedge clk);
    run(4, 4'd1);
    read_time(t);
    check("R6 applied increment", t,
          expect_ns(64'd0, 48'h1_1111_1111, 4, 48'h5_0000_0000, 4));

    // R8 coherent split read across a low-word wrap
    load_time(64'h5_FFFF_FFC0);
    set_inc(48'h10_0000_0000);
    wr(3'd0, 32'h101);
    repeat (2) @(negedge clk);
    rd(3'd6, d);
    t[31:0] = d;
    repeat (6) @(negedge clk);
    rd(3'd7, d);
    t[63:32] = d;
    wr(3'd0, 32'h100);
    check("R8 coherent snapshot", t, 64'h5_FFFF_FFE0);
    read_time(t2);
    check("R8 time after wrap", {31'h0, (t2[63:32] == 32'h6)}, 64'h1);

    // R2 random increments, fraction carried across apply
    for (int i = 0; i < 20; i++) begin
      logic [63:0] t0;
      logic [47:0] a1, a2;
      int n1, n2;
      t0 = {$urandom, $urandom};
      a1 = {16'($urandom % 20), $urandom};
      a2 = {16'($urandom), $urandom};
      n1 = 1 + int'($urandom % 64);
      n2 = 1 + int'($urandom % 64);
      load_time(t0);
      set_inc(a1);
      run(n1, 4'd1);
      set_inc(a2);
      run(n2, 4'd1);
      read_time(t);
      check("R2 random accumulate", t, expect_ns(t0, a1, n1, a2, n2));
      check("R9 random ts_out", {24'h0, ts_out}, {24'h0, t[39:0]});
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule